// File: doc/BRIEF.md
# Offset-Matching Byte Copy Engine

This engine copies a run of bytes between two byte addresses over one 32-bit memory port that takes byte-enable writes. When it starts, it compares the low two bits of the source and destination addresses. If those bits are equal, the two pointers can reach word alignment together. In that case the engine copies single bytes until the source is aligned, moves whole words through the middle, and finishes with single bytes. If the bits differ, it still aligns the source one byte at a time. It then reads whole source words into a holding register and writes each word out as four single-byte writes, lowest lane first.

The memory answers a read one cycle after it sees the address. A byte step takes one read cycle and one write cycle. A word step on the matched path also takes two cycles. A word step on the mismatched path takes five cycles: one read and four writes. The engine accepts a start pulse only while it is idle. It raises `done` for exactly one cycle after its final write, or one cycle after a start with a zero length.

Top module: `align_copy_engine`

## Requirements
- R1: After reset, `busy` and `done` are low. No write is issued while the engine is idle.
- R2: A start with length 0 raises `done` on the cycle after the start. No write is issued for it.
- R3: When source and destination have equal low two bits, the engine copies single bytes until the source is word aligned. It then writes whole words with `mem_be`=4'b1111 at word-aligned destinations, each directly after a word read, and copies the remaining 1 to 3 bytes singly.
- R4: When both addresses are word aligned and the length is a multiple of 4, every write is a full 4-byte word write.
- R5: When the low two bits differ, no full-word write ever occurs. Each source word read is followed by four single-byte writes of lanes 0, 1, 2, 3 of that word, in that order, to consecutive destination addresses.
- R6: When the length is smaller than the number of bytes needed to align the source, only that many single-byte copies take place, and no word read occurs.
- R7: On the mismatched path, when fewer than 4 bytes remain after source alignment, those bytes are copied with single-byte reads and writes.
- R8: After `done`, destination bytes dst..dst+len-1 hold the source bytes src..src+len-1. The bytes just before and just after that range are unchanged.
- R9: A start pulse while the engine is busy is ignored. It causes no extra writes and does not change the copy in progress.
- R10: `done` is high for exactly one cycle, on the cycle after the final write, with `busy` low. The start-to-done latency is 2 cycles per byte step, 2 per matched word step, 5 per mismatched word step, plus 1.
- R11: A single-byte write has exactly one enable bit set, bit `mem_addr[1:0]`. Its byte value is replicated on all four lanes of `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only while idle |
| src | input | 32 | Source byte address |
| dst | input | 32 | Destination byte address |
| len | input | 32 | Number of bytes to copy |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 32 | Byte address for the read or write in this cycle |
| mem_we | output | 1 | Write strobe |
| mem_be | output | 4 | Byte-lane enables for a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data for the address of the previous cycle |

## Verification
The checker tests on every cycle the shape of each access. It checks the one-hot byte enables and their lane position, and that full-word writes are aligned and always directly follow a word read. It checks that full-word writes never happen on the mismatched path, that `done` lasts a single cycle, that a zero-length start completes in one cycle, and that the engine is silent while idle. Other properties depend on a whole transfer and need the bench's scenarios: the exact order of head, body and tail writes for each offset pairing, the byte values that end up in memory, the untouched neighbours of the destination range, the total latency, and the rejection of a start during a copy.

// File: rtl/acp_pkg.sv
package acp_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_SEL_W = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {K_NONE, K_BYTE, K_WORD} acp_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_BRD, S_BWR, S_WRD, S_WWR, S_SWR, S_DONE
  } acp_state_e;

  // Both pointers reach word alignment together when their low bits match.
  function automatic logic same_offset(logic [LANE_SEL_W-1:0] a,
                                       logic [LANE_SEL_W-1:0] b);
    return a == b;
  endfunction

  // Next state after a step, chosen from the kind of the next step.
  function automatic acp_state_e phase_for(acp_kind_e k);
    case (k)
      K_BYTE:  return S_BRD;
      K_WORD:  return S_WRD;
      default: return S_DONE;
    endcase
  endfunction
endpackage

// File: rtl/acp_plan.sv
module acp_plan #(
  parameter int LEN_W = 32
) (
  input  logic [acp_pkg::LANE_SEL_W-1:0] src_lo,
  input  logic [LEN_W-1:0]              remain,
  output acp_pkg::acp_kind_e            kind
);
  import acp_pkg::*;

  always_comb begin
    if (remain == '0)
      kind = K_NONE;
    else if (src_lo != '0 || remain < LEN_W'(WORD_BYTES))
      kind = K_BYTE;
    else
      kind = K_WORD;
  end
endmodule

// File: rtl/acp_lane.sv
module acp_lane #(
  parameter int LANES = 4,
  parameter int SEL_W = 2
) (
  input  logic [8*LANES-1:0] word_in,
  input  logic [SEL_W-1:0]   pick,
  input  logic [SEL_W-1:0]   put,
  output logic [7:0]         byte_out,
  output logic [LANES-1:0]   be,
  output logic [8*LANES-1:0] wdata
);
  assign byte_out = word_in[8*pick +: 8];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i]          = (put == SEL_W'(i));
    assign wdata[8*i +: 8] = byte_out;
  end
endmodule

// File: rtl/align_copy_engine.sv
module align_copy_engine #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  import acp_pkg::*;

  localparam int DATA_W = 8 * WORD_BYTES;
  localparam logic [LANE_SEL_W-1:0] LAST_LANE = LANE_SEL_W'(WORD_BYTES - 1);

  acp_state_e              state;
  logic [ADDR_W-1:0]       sp, dp, nsp, ndp;
  logic [LEN_W-1:0]        rem, nrem;
  logic                    matched_q;
  logic [LANE_SEL_W-1:0]   lane_q;
  logic [DATA_W-1:0]       hold_q;

  // Named events for the checker
  logic word_rd_evt, full_wr_evt, step_end;
  assign word_rd_evt = (state == S_WRD);
  assign full_wr_evt = (state == S_WWR);
  assign step_end    = (state == S_BWR) || (state == S_WWR) ||
                       (state == S_SWR && lane_q == LAST_LANE);

  // Pointer arithmetic for the step completing in this cycle
  always_comb begin
    nsp  = sp;
    ndp  = dp;
    nrem = rem;
    case (state)
      S_BWR: begin
        nsp = sp + ADDR_W'(1); ndp = dp + ADDR_W'(1); nrem = rem - LEN_W'(1);
      end
      S_WWR: begin
        nsp  = sp + ADDR_W'(WORD_BYTES);
        ndp  = dp + ADDR_W'(WORD_BYTES);
        nrem = rem - LEN_W'(WORD_BYTES);
      end
      S_SWR: begin
        nsp  = (lane_q == LAST_LANE) ? sp + ADDR_W'(WORD_BYTES) : sp;
        ndp  = dp + ADDR_W'(1);
        nrem = rem - LEN_W'(1);
      end
      default: ;
    endcase
  end

  // Step planner: fed from the inputs at start, else from the next pointers
  logic [LANE_SEL_W-1:0] plan_lo;
  logic [LEN_W-1:0]      plan_rem;
  acp_kind_e             plan_kind;
  assign plan_lo  = (state == S_IDLE) ? src[LANE_SEL_W-1:0] : nsp[LANE_SEL_W-1:0];
  assign plan_rem = (state == S_IDLE) ? len : nrem;

  acp_plan #(.LEN_W(LEN_W)) u_plan (
    .src_lo (plan_lo),
    .remain (plan_rem),
    .kind   (plan_kind)
  );

  // Byte lane extraction and placement
  logic [LANE_SEL_W-1:0] pick_sel;
  logic [DATA_W-1:0]     lane_src;
  logic [7:0]            lane_byte;
  logic [3:0]            lane_be;
  logic [DATA_W-1:0]     lane_wdata;
  assign pick_sel = (state == S_SWR) ? lane_q : sp[LANE_SEL_W-1:0];
  assign lane_src = (state == S_SWR && lane_q != '0) ? hold_q : mem_rdata;

  acp_lane #(.LANES(WORD_BYTES), .SEL_W(LANE_SEL_W)) u_lane (
    .word_in  (lane_src),
    .pick     (pick_sel),
    .put      (dp[LANE_SEL_W-1:0]),
    .byte_out (lane_byte),
    .be       (lane_be),
    .wdata    (lane_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sp        <= '0;
      dp        <= '0;
      rem       <= '0;
      matched_q <= 1'b0;
      lane_q    <= '0;
      hold_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          sp        <= src;
          dp        <= dst;
          rem       <= len;
          matched_q <= same_offset(src[LANE_SEL_W-1:0], dst[LANE_SEL_W-1:0]);
          lane_q    <= '0;
          state     <= phase_for(plan_kind);
        end
        S_BRD: state <= S_BWR;
        S_WRD: state <= matched_q ? S_WWR : S_SWR;
        S_BWR, S_WWR, S_SWR: begin
          sp  <= nsp;
          dp  <= ndp;
          rem <= nrem;
          if (state == S_SWR) begin
            if (lane_q == '0) hold_q <= mem_rdata;
            lane_q <= lane_q + LANE_SEL_W'(1);
          end
          if (step_end) state <= phase_for(plan_kind);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_be    = '0;
    mem_wdata = '0;
    case (state)
      S_BRD, S_WRD: mem_addr = sp;
      S_WWR: begin
        mem_addr = dp; mem_we = 1'b1; mem_be = '1; mem_wdata = mem_rdata;
      end
      S_BWR, S_SWR: begin
        mem_addr = dp; mem_we = 1'b1; mem_be = lane_be; mem_wdata = lane_wdata;
      end
      default: ;
    endcase
  end

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);
endmodule

// File: rtl/acp_checker.sv
module acp_checker #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] len,
  input logic             busy,
  input logic             done,
  input logic             mem_we,
  input logic [3:0]       mem_be,
  input logic [1:0]       addr_lo,
  input logic             word_rd_evt,
  input logic             full_wr_evt,
  input logic             matched_q
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);
  // R2
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && len == '0) |=> done);
  // R3
  full_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr_evt |-> (mem_we && mem_be == 4'hF && addr_lo == 2'd0));
  // R3
  full_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr_evt |-> $past(word_rd_evt));
  // R5
  split_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !matched_q) |-> !(mem_we && mem_be == 4'hF));
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_we));
  // R11
  byte_be_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != 4'hF) |-> $onehot(mem_be));
  // R11
  byte_lane_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_be != 4'hF) |-> mem_be == (4'b0001 << addr_lo));
endmodule

bind align_copy_engine acp_checker #(.LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .len         (len),
  .busy        (busy),
  .done        (done),
  .mem_we      (mem_we),
  .mem_be      (mem_be),
  .addr_lo     (mem_addr[1:0]),
  .word_rd_evt (word_rd_evt),
  .full_wr_evt (full_wr_evt),
  .matched_q   (matched_q)
);

// File: tb/align_copy_engine_bench.sv
module align_copy_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] src, dst, len;
  logic        busy, done;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  align_copy_engine u_align_copy_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src), .dst(dst), .len(len),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Single-cycle memory model: read data one cycle after the address
  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    mem_rdata <= {mem[{mem_addr[9:2], 2'd3}], mem[{mem_addr[9:2], 2'd2}],
                  mem[{mem_addr[9:2], 2'd1}], mem[{mem_addr[9:2], 2'd0}]};
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[{mem_addr[9:2], 2'(b)}] <= mem_wdata[8*b +: 8];
  end

  function automatic logic [7:0] pattern(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    string       tag;
  } wr_t;
  wr_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  task automatic report(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares each write against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        report(1'b0, cur_tag, "unexpected write addr/be", {mem_be, mem_addr}, 0);
      end else begin
        wr_t e;
        logic [31:0] mask;
        e = exp_q.pop_front();
        for (int b = 0; b < 4; b++) mask[8*b +: 8] = {8{e.be[b]}};
        report(mem_addr == e.addr && mem_be == e.be &&
               (mem_wdata & mask) == (e.data & mask), e.tag, "write {be,addr,data}",
               {mem_be, mem_addr, mem_wdata & mask}, {e.be, e.addr, e.data & mask});
      end
    end
  end

  // Driver side: expected write stream and latency from the requirements
  task automatic plan_writes(int s, int d, int n, string tag, output int cyc);
    cyc = 1;
    while (n > 0) begin
      if ((s % 4) != 0 || n < 4) begin
        exp_q.push_back('{32'(d), 4'(1 << (d % 4)), {4{pattern(s)}}, tag});
        s++; d++; n--; cyc += 2;
      end else if ((s % 4) == (d % 4)) begin
        exp_q.push_back('{32'(d), 4'hF,
          {pattern(s+3), pattern(s+2), pattern(s+1), pattern(s)}, tag});
        s += 4; d += 4; n -= 4; cyc += 2;
      end else begin
        for (int k = 0; k < 4; k++) begin
          exp_q.push_back('{32'(d), 4'(1 << (d % 4)), {4{pattern(s+k)}}, tag});
          d++; n--;
        end
        s += 4; cyc += 5;
      end
    end
  endtask

  task automatic run_case(int s, int d, int n, string tag, bit poke);
    int exp_cyc, cyc;
    bit ok;
    @(negedge clk);
    for (int i = 0; i < 1024; i++) mem[i] = pattern(i);
    cur_tag = tag;
    plan_writes(s, d, n, tag, exp_cyc);
    src = 32'(s); dst = 32'(d); len = 32'(n); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (poke && !done) begin
      // R9: stray start while busy, aimed at a region that must stay untouched
      src = 32'h0; dst = 32'h300; len = 32'd8; start = 1'b1;
    end
    while (!done && cyc < 2000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    report(cyc == exp_cyc, tag == "R2" ? "R2" : "R10", "start-to-done cycles", cyc, exp_cyc);
    report(exp_q.size() == 0, tag, "missing writes", exp_q.size(), 0);
    exp_q.delete();
    ok = 1'b1;
    for (int i = 0; i < n; i++) if (mem[d+i] != pattern(s+i)) ok = 1'b0;
    report(ok, "R8", "destination contents match", ok, 1);
    report(mem[d-1] == pattern(d-1) && mem[d+n] == pattern(d+n), "R8",
           "neighbour bytes untouched", {mem[d-1], mem[d+n]}, {pattern(d-1), pattern(d+n)});
    if (poke) begin
      ok = 1'b1;
      for (int i = 0; i < 8; i++) if (mem[32'h300+i] != pattern(32'h300+i)) ok = 1'b0;
      report(ok, "R9", "stray start region untouched", ok, 1);
    end
    @(negedge clk);
    report(!done && !busy, "R10", "done lasts one cycle {done,busy}", {done, busy}, 0);
  endtask

  initial begin
    #(200000 * 10);
    report(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; src = '0; dst = '0; len = '0;
    for (int i = 0; i < 1024; i++) mem[i] = pattern(i);
    repeat (3) @(negedge clk);
    report(!busy && !done && !mem_we, "R1", "reset outputs {busy,done,we}",
           {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    report(!busy && !done && !mem_we, "R1", "idle outputs {busy,done,we}",
           {busy, done, mem_we}, 0);

    run_case(32'h010, 32'h210, 16, "R4", 1'b0);  // both aligned, 4 words
    run_case(32'h011, 32'h215, 13, "R3", 1'b0);  // head 3, 2 words, tail 2
    run_case(32'h013, 32'h220, 11, "R5", 1'b0);  // head 1, 2 split words, tail 2
    run_case(32'h021, 32'h240, 2,  "R6", 1'b0);  // shorter than the head
    run_case(32'h030, 32'h260, 0,  "R2", 1'b0);  // zero length
    run_case(32'h032, 32'h271, 4,  "R7", 1'b0);  // head 2, 2 left: bytes only
    run_case(32'h041, 32'h285, 9,  "R9", 1'b1);  // start pulsed while busy
    run_case(32'h056, 32'h2A1, 7,  "R11", 1'b0); // mismatched byte lanes

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule